// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing part of a 2 KB serial memory. It takes the raw clock and data lines of a two-wire bus, passes them through two-flop synchronizers on the system clock, and finds start and stop conditions and clock edges. After a start it shifts in a control byte. The upper nibble of that byte is the device code. The next three bits pick one of eight 256-byte blocks. The low bit chooses between a write and a read.

Writes pass a word address and then data bytes to a write buffer. The address is loaded into an 11-bit pointer. Each data byte leaves on a one-cycle strobe together with the address it belongs to. A stop after at least one data byte raises a commit strobe, and the buffer starts its internal write cycle on it. Reads shift bytes taken from the memory array onto the bus, most significant bit first. The slave pulls the data line low to acknowledge on the ninth clock. It stays silent when the device code is wrong or while the buffer reports a write in progress.

The controller is a state machine with these states: `ST_IDLE`, `ST_CTRL`, `ST_CTRL_ACK`, `ST_WADDR`, `ST_WADDR_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA` and `ST_RACK`.
- A stop sends every state to `ST_IDLE`, and a start sends every state to `ST_CTRL`.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a good control byte, and to `ST_IDLE` on a bad code or while busy.
- `ST_CTRL_ACK` goes to `ST_WADDR` for a write and to `ST_RDATA` for a read.
- `ST_WADDR` goes to `ST_WADDR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate for each data byte.
- `ST_RDATA` goes to `ST_RACK`. `ST_RACK` returns to `ST_RDATA` when the master acknowledges, and goes to `ST_IDLE` when it does not.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A start (data line falling while the clock line is high) begins a new control byte from any state and drops any partly received byte. A stop (data line rising while the clock line is high) returns the slave to idle. In idle, bytes clocked without a start get no acknowledge.
- R2: When bits 7:4 of the control byte equal binary 1010, the slave pulls the data line low during the ninth clock. On any other code it leaves the line released, for this byte and every later one, until the next start.
- R3: Control byte bits 3:1 become bits 10:8 of `mem_addr`, in both writes and reads.
- R4: Control byte bit 0 selects the operation: 0 is a write, 1 is a read.
- R5: In a write, the byte after the control byte is loaded into `mem_addr[7:0]` and acknowledged.
- R6: Each later write byte is acknowledged and sent out on a one-cycle `wr_stb`, with `wr_data` and the current `mem_addr`. After each byte, `mem_addr[3:0]` steps by one and wraps within the 16-byte page, and `mem_addr[10:4]` does not change.
- R7: If `wr_busy` is high when the control byte completes, the slave does not acknowledge and goes idle.
- R8: In a read, the slave shifts out `rd_data` for the current `mem_addr`, most significant bit first. The slave changes the data line only while the clock line is low. After each byte, `rd_next` pulses and `mem_addr` steps by one across all 11 bits. A master acknowledge continues the read; a missing acknowledge releases the line until the next start or stop.
- R9: A stop after a write that carried at least one data byte gives a one-cycle `stop_stb`. A read, a write of the address only, or an aborted transfer gives none.
- R10: Incoming bits are taken on rising edges of the clock line, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, raw |
| sda_i | input | 1 | Bus data line, raw |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_busy | input | 1 | Internal write cycle running |
| mem_addr | output | 11 | Address pointer, block bits on top |
| rd_data | input | 8 | Memory byte at `mem_addr` |
| rd_next | output | 1 | One-cycle pulse per byte read out |
| wr_stb | output | 1 | One-cycle pulse per byte written |
| wr_data | output | 8 | Byte that goes with `wr_stb` |
| stop_stb | output | 1 | Commit pulse at a stop after write data |

## Verification
A state machine that loses track of the bit count shows up on the bus within one byte. Either the acknowledge lands on the wrong clock and the master sees a missing or extra low on its ninth clock, or a read byte comes out shifted. A pointer fault shows on the next `wr_stb` as a wrong address, or on the next read as the wrong pattern byte. A missed start or stop shows at the very next control byte, which is then not acknowledged, or is acknowledged when it should not be. The bench compares every strobed write against a queue of expected address and data pairs, and it checks that the data line never moves while the clock line is high.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } i2cs_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] q,
    output logic [LINES-1:0] q_d
);
    // Each line gets its own synchronizer chain. Reset value 1 matches the idle bus.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign q[g] = pipe[STAGES-1];
    end

    // One more flop per line, so the top can see edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_d <= '1;
        else        q_d <= q;
    end
endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr #(
    parameter int ADDR_W = 11,
    parameter int BLK_W  = 3,
    parameter int PAGE_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_blk,
    input  logic [BLK_W-1:0]        blk,
    input  logic                    set_word,
    input  logic [ADDR_W-BLK_W-1:0] word,
    input  logic                    inc_page,
    input  logic                    inc_lin,
    output logic [ADDR_W-1:0]       ptr
);
    localparam int WORD_W = ADDR_W - BLK_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            if (set_blk)  ptr[ADDR_W-1:WORD_W] <= blk;
            if (set_word) ptr[WORD_W-1:0]      <= word;
            // A page step wraps inside the low bits and leaves the upper bits alone.
            if (inc_page) ptr[PAGE_W-1:0]      <= ptr[PAGE_W-1:0] + 1'b1;
            // A read step carries across the full address.
            if (inc_lin)  ptr                  <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int BLK_W       = 3,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              wr_busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        rd_data,
    output logic              rd_next,
    output logic              wr_stb,
    output logic [7:0]        wr_data,
    output logic              stop_stb
);
    localparam int WORD_W = ADDR_W - BLK_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    // ---------------- line synchronizers and bus events ----------------
    logic [1:0] lines_s, lines_d;
    logic scl_s, sda_s, scl_d, sda_d;

    i2cs_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_i, sda_i}),
        .q     (lines_s),
        .q_d   (lines_d)
    );

    assign {scl_s, sda_s} = lines_s;
    assign {scl_d, sda_d} = lines_d;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

    // ---------------- registers ----------------
    i2cs_state_e          st_q, st_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [BYTE_W-1:0]    sh_q;
    logic                 oe_q;
    logic                 wrote_q;
    logic                 mack_q;
    logic                 wr_stb_q, stop_stb_q, rd_next_q;
    logic [BYTE_W-1:0]    wr_data_q;

    logic byte_full, ctrl_ok, ctrl_rw;
    assign byte_full = (cnt_q == FULL_CNT);
    assign ctrl_ok   = (sh_q[7:4] == DEV_CODE) && !wr_busy;
    assign ctrl_rw   = sh_q[0];

    // ---------------- address pointer ----------------
    logic set_blk, set_word;
    assign set_blk  = (st_q == ST_CTRL)  && scl_fall && byte_full && ctrl_ok;
    assign set_word = (st_q == ST_WADDR) && scl_fall && byte_full;

    i2cs_ptr #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_blk  (set_blk),
        .blk      (sh_q[BLK_W:1]),
        .set_word (set_word),
        .word     (sh_q[WORD_W-1:0]),
        .inc_page (wr_stb_q),
        .inc_lin  (rd_next_q),
        .ptr      (mem_addr)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        st_d = st_q;
        if (stop_ev) begin
            st_d = ST_IDLE;
        end else if (start_ev) begin
            st_d = ST_CTRL;
        end else begin
            unique case (st_q)
                ST_IDLE:      st_d = ST_IDLE;
                ST_CTRL:      if (scl_fall && byte_full) st_d = ctrl_ok ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK:  if (scl_fall) st_d = ctrl_rw ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (scl_fall && byte_full) st_d = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) st_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_full) st_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) st_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_full) st_d = ST_RACK;
                ST_RACK:      if (scl_fall) st_d = mack_q ? ST_RDATA : ST_IDLE;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sh_q       <= '0;
            oe_q       <= 1'b0;
            wrote_q    <= 1'b0;
            mack_q     <= 1'b0;
            wr_stb_q   <= 1'b0;
            stop_stb_q <= 1'b0;
            rd_next_q  <= 1'b0;
            wr_data_q  <= '0;
        end else begin
            wr_stb_q   <= 1'b0;
            stop_stb_q <= 1'b0;
            rd_next_q  <= 1'b0;
            if (stop_ev) begin
                oe_q       <= 1'b0;
                stop_stb_q <= wrote_q;
                wrote_q    <= 1'b0;
                cnt_q      <= '0;
            end else if (start_ev) begin
                oe_q    <= 1'b0;
                wrote_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                case (st_q)
                    ST_CTRL, ST_WADDR, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            cnt_q <= '0;
                            oe_q  <= (st_q != ST_CTRL) || ctrl_ok;
                            if (st_q == ST_WDATA) begin
                                wr_stb_q  <= 1'b1;
                                wr_data_q <= sh_q;
                                wrote_q   <= 1'b1;
                            end
                        end
                    end
                    ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            oe_q  <= 1'b0;
                            cnt_q <= '0;
                            if (st_q == ST_CTRL_ACK && ctrl_rw) begin
                                sh_q <= rd_data;
                                oe_q <= ~rd_data[BYTE_W-1];
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && !byte_full) cnt_q <= cnt_q + 1'b1;
                        if (scl_fall) begin
                            if (byte_full) begin
                                oe_q <= 1'b0;
                            end else begin
                                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                                oe_q <= ~sh_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q    <= ~sda_s;
                            rd_next_q <= 1'b1;
                        end
                        if (scl_fall && mack_q) begin
                            sh_q  <= rd_data;
                            oe_q  <= ~rd_data[BYTE_W-1];
                            cnt_q <= '0;
                        end
                    end
                    default: oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe   = oe_q;
    assign wr_stb   = wr_stb_q;
    assign wr_data  = wr_data_q;
    assign stop_stb = stop_stb_q;
    assign rd_next  = rd_next_q;

    // ---------------- assertions ----------------
    // R1
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q == ST_CTRL) && !sda_oe);

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st_q == ST_IDLE));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !sda_oe);

    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R6
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (mem_addr[PAGE_W-1:0] == $past(mem_addr[PAGE_W-1:0]) + 1'b1)
                && (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, stop_stb, rd_next}));
endmodule

// File: tb/sim_eeprom_i2c_slave.sv
module sim_eeprom_i2c_slave;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        wr_busy = 1'b0;
    logic        sda_oe, rd_next, wr_stb, stop_stb;
    logic [10:0] mem_addr;
    logic [7:0]  rd_data, wr_data;
    logic        sda_line;

    assign sda_line = sda_m & ~sda_oe;

    function automatic logic [7:0] rd_pat(logic [10:0] a);
        return a[7:0] ^ {2'b00, a[10:8], 3'b101};
    endfunction
    assign rd_data = rd_pat(mem_addr);

    always #(CLK_P/2) clk = ~clk;

    eeprom_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .wr_busy(wr_busy), .mem_addr(mem_addr), .rd_data(rd_data), .rd_next(rd_next),
        .wr_stb(wr_stb), .wr_data(wr_data), .stop_stb(stop_stb)
    );

    int errs = 0, checks = 0;
    int stop_cnt = 0, rd_cnt = 0, oe_bad = 0;
    logic oe_prev = 1'b0;
    logic [18:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Monitor: pops the scoreboard on every write strobe, counts pulses, watches the data line.
    always @(negedge clk) begin
        logic [18:0] item;
        if (rst_n) begin
            if (wr_stb) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected wr_stb addr/data", {mem_addr, wr_data}, 0);
                end else begin
                    item = exp_q.pop_front();
                    chk({mem_addr, wr_data} == item, "R6", "write addr/data", {mem_addr, wr_data}, item);
                end
            end
            if (stop_stb) stop_cnt++;
            if (rd_next)  rd_cnt++;
            if (sda_oe != oe_prev && scl) oe_bad++;
            oe_prev = sda_oe;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c;
        wclk(5); sda_m = 1'b1; wclk(15); scl = 1'b1; wclk(10); sda_m = 1'b0; wclk(10); scl = 1'b0;
    endtask

    task automatic stop_c;
        wclk(5); sda_m = 1'b0; wclk(15); scl = 1'b1; wclk(10); sda_m = 1'b1; wclk(10);
    endtask

    task automatic send_bit(input logic b);
        wclk(5); sda_m = b; wclk(15); scl = 1'b1; wclk(20); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        wclk(5); sda_m = 1'b1; wclk(15); scl = 1'b1; wclk(10); ack = ~sda_line; wclk(10); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(20); scl = 1'b1; wclk(10); d[i] = sda_line; wclk(10); scl = 1'b0;
        end
        wclk(5); sda_m = ~mack; wclk(15); scl = 1'b1; wclk(20); scl = 1'b0;
    endtask

    // Driver: pushes expected writes and checks acknowledges and read bytes.
    initial begin
        logic       ack;
        logic [7:0] d;
        int         nacks;
        wclk(5);
        chk(sda_oe == 1'b0 && wr_stb == 1'b0 && stop_stb == 1'b0 && rd_next == 1'b0,
            "R1", "reset outputs quiet", {sda_oe, wr_stb, stop_stb, rd_next}, 0);
        chk(mem_addr == 11'h000, "R3", "reset address", mem_addr, 0);
        rst_n = 1'b1;
        wclk(10);

        // Byte write, block 3
        start_c;
        send_byte(8'hA6, ack); chk(ack, "R2", "ack on device code 1010 write", ack, 1);
        send_byte(8'h5C, ack); chk(ack, "R5", "ack on word address", ack, 1);
        chk(mem_addr == 11'h35C, "R3", "block bits on top of address", mem_addr, 11'h35C);
        exp_q.push_back({11'h35C, 8'hA7});
        send_byte(8'hA7, ack); chk(ack, "R10", "ack on data byte", ack, 1);
        stop_c;
        chk(stop_cnt == 1, "R9", "commit strobe after byte write", stop_cnt, 1);

        // Page write with wrap, block 5, 18 bytes from 0xFE
        start_c;
        send_byte(8'hAA, ack); chk(ack, "R4", "write control ack", ack, 1);
        send_byte(8'hFE, ack);
        nacks = 0;
        for (int i = 0; i < 18; i++) begin
            logic [3:0] lo;
            lo = 4'(14 + i);
            exp_q.push_back({3'd5, 4'hF, lo, 8'(8'h30 + i)});
            send_byte(8'(8'h30 + i), ack);
            if (!ack) nacks++;
        end
        chk(nacks == 0, "R6", "all page bytes acknowledged", nacks, 0);
        chk(mem_addr == 11'h5F0, "R6", "page pointer wrapped", mem_addr, 11'h5F0);
        stop_c;
        chk(stop_cnt == 2, "R9", "commit strobe after page write", stop_cnt, 2);

        // Wrong device code: no ack now or later
        start_c;
        send_byte(8'hB0, ack); chk(!ack, "R2", "no ack on wrong code", ack, 0);
        send_byte(8'h12, ack); chk(!ack, "R2", "bus ignored after wrong code", ack, 0);
        stop_c;
        chk(stop_cnt == 2, "R9", "no commit after ignored transfer", stop_cnt, 2);

        // Busy
        wr_busy = 1'b1;
        start_c;
        send_byte(8'hA0, ack); chk(!ack, "R7", "no ack while write busy", ack, 0);
        stop_c;
        wr_busy = 1'b0;

        // Random read: set pointer 0x210, repeated start, read three bytes
        start_c;
        send_byte(8'hA4, ack); chk(ack, "R7", "ack again once not busy", ack, 1);
        send_byte(8'h10, ack);
        start_c;
        send_byte(8'hA5, ack); chk(ack, "R4", "read control ack", ack, 1);
        recv_byte(1'b1, d); chk(d == rd_pat(11'h210), "R8", "read byte 0", d, rd_pat(11'h210));
        recv_byte(1'b1, d); chk(d == rd_pat(11'h211), "R8", "read byte 1", d, rd_pat(11'h211));
        recv_byte(1'b0, d); chk(d == rd_pat(11'h212), "R8", "read byte 2", d, rd_pat(11'h212));
        stop_c;
        chk(rd_cnt == 3, "R8", "read step pulses", rd_cnt, 3);
        chk(mem_addr == 11'h213, "R8", "pointer after reads", mem_addr, 11'h213);
        chk(stop_cnt == 2, "R9", "no commit after read", stop_cnt, 2);

        // Current-address read with block 6 in the read control byte
        start_c;
        send_byte(8'hAD, ack); chk(ack, "R3", "read block 6 ack", ack, 1);
        recv_byte(1'b0, d); chk(d == rd_pat(11'h613), "R3", "read uses new block bits", d, rd_pat(11'h613));
        stop_c;
        chk(sda_oe == 1'b0, "R8", "line released after nack", sda_oe, 0);

        // Start aborts a partial byte; address-only write gives no commit
        start_c;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        start_c;
        send_byte(8'hA0, ack); chk(ack, "R1", "ack after restart mid-byte", ack, 1);
        send_byte(8'h33, ack);
        chk(mem_addr == 11'h033, "R5", "word address loaded", mem_addr, 11'h033);
        stop_c;
        chk(stop_cnt == 2, "R9", "no commit for address-only write", stop_cnt, 2);

        // Idle after stop: a byte without start is ignored
        send_byte(8'hA0, ack); chk(!ack, "R1", "no ack without start", ack, 0);
        stop_c;

        wclk(20);
        chk(oe_bad == 0, "R8", "data line moved with clock high", oe_bad, 0);
        chk(exp_q.size() == 0, "R6", "writes still expected", exp_q.size(), 0);
        finish_run;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        finish_run;
    end
endmodule